// File: doc/BRIEF.md
# Multiplexed Address/Data Bus Target

This block is the target side of a synchronous bus that uses one set of data lines for both address and data. An access opens with a one-clock address strobe. On that clock the target takes the byte address from the low 26 data lines, a three-bit transfer-size code from the top three data lines, and a direction bit from a separate read/write input. A data phase follows on the same lines. Each clock of the data phase moves one beat to or from a simple synchronous memory port. The target adds no wait states.

A transfer wider than the data path is carried as a run of beats after a single address. The 32-byte burst is the main case, and so is the quadword on a 32-bit path. The first beat carries the requested word. The following beats step upward and wrap inside the naturally aligned block of the transfer's size. The initiator lowers the frame signal on the final beat. Narrow writes reach the memory with byte-lane enables taken from the size and the low address bits, using little-endian lane numbering. The data path is 32 or 64 bits wide, set by a parameter.

Top module: `mux_bus_target`

## Requirements
- R1: While reset is asserted and in the first idle cycle after it, `dq_oe` and `mem_wen` are low.
- R2: On a clock where `bus_start` and `sel` are both high and no data phase is open, the target latches three things: the byte address from `dq_in[25:0]`, the size code from `dq_in[DW-1:DW-3]`, and the direction from `rd_nwr` (1 = read, 0 = write). Every other data line is ignored on that clock.
- R3: Size codes map to transfer spans as follows: 000 is 1 byte, 001 is 2 bytes, 010 is 4 bytes, 011 is 8 bytes. Any code with the top bit set (1xx) is a 32-byte burst, and its two low bits are ignored.
- R4: A transfer has max(1, span/(DW/8)) beats. A 32-byte burst is therefore 4 beats on a 64-bit path and 8 beats on a 32-bit path. No extra beat is ever produced.
- R5: The beat word address (`mem_addr` = byte address / (DW/8)) starts at the requested word. It increments by one each beat and wraps inside the span-aligned block.
- R6: The data phase starts on the clock after the strobe. The beat during which `frame` is low is the last one. A new strobe is accepted on the very next clock, with no idle clock in between.
- R7: On each write beat `mem_wen` is high and `mem_wdata` equals `dq_in` of that clock.
- R8: On each read beat `dq_oe` is high and `dq_out` equals `mem_rdata` for the addressed word. `dq_oe` is low on every other clock, including the address clock.
- R9: Byte lane i of `mem_be` is set exactly when floor(i/span) equals floor(offset/span), where offset is the byte address modulo DW/8. When the span is at least DW/8, all lanes are set.
- R10: A strobe with `sel` low is ignored. No beat, no memory write and no output drive follow it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_start | input | 1 | Address-phase strobe, high for one clock |
| sel | input | 1 | Target select, high for the whole access |
| frame | input | 1 | High through the access, low on the final beat |
| rd_nwr | input | 1 | Direction, sampled with the strobe: 1 read, 0 write |
| dq_in | input | DW | Shared address/data lines as seen by the target |
| dq_out | output | DW | Read data driven onto the shared lines |
| dq_oe | output | 1 | Output enable for `dq_out` |
| mem_addr | output | 26-log2(DW/8) | Word address of the current beat |
| mem_wen | output | 1 | Memory write strobe |
| mem_be | output | DW/8 | Byte-lane enables of the write |
| mem_wdata | output | DW | Memory write data |
| mem_rdata | input | DW | Memory read data for `mem_addr`, same clock |

## Verification
Some properties hold on every cycle, and the assertions check these. The target never drives the lines while the address is on them, and it never reads and writes memory on the same beat. A write always has at least one lane enabled. A strobe without select is never followed by a beat. The beat counter never passes the length derived from the size code. Beat addresses never leave their aligned block. Other behaviour depends on the data an access carries, and only the scoreboard scenarios can show it. This covers the exact wrap order for every size code and start offset, the lane pattern of each narrow write, the data read back after earlier writes, and whether back-to-back accesses at minimum pitch produce exactly the expected number of beats.

// File: rtl/mbt_pkg.sv
package mbt_pkg;

  typedef enum logic {
    PH_IDLE = 1'b0,
    PH_DATA = 1'b1
  } phase_t;

  localparam int unsigned BURST_LG = 5;  // 32-byte burst span, log2

  // log2 of the transfer span in bytes for a size code
  function automatic logic [2:0] span_lg(input logic [2:0] code);
    return code[2] ? 3'(BURST_LG) : {1'b0, code[1:0]};
  endfunction

endpackage

// File: rtl/mbt_phase_ctrl.sv
module mbt_phase_ctrl
  import mbt_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic bus_start,
  input  logic sel,
  input  logic frame,
  input  logic rd_nwr,
  output logic capture,
  output logic beat,
  output logic rd_q
);

  phase_t phase_q, phase_d;
  logic   rd_d;
  logic   last;

  assign capture = bus_start && sel && (phase_q == PH_IDLE);
  assign beat    = (phase_q == PH_DATA) && sel;
  assign last    = beat && !frame;

  always_comb begin
    phase_d = phase_q;
    rd_d    = rd_q;
    unique case (phase_q)
      PH_IDLE: begin
        if (capture) begin
          phase_d = PH_DATA;
          rd_d    = rd_nwr;
        end
      end
      PH_DATA: begin
        if (last || !sel) phase_d = PH_IDLE;
      end
      default: phase_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      rd_q    <= 1'b0;
    end else begin
      phase_q <= phase_d;
      if (capture) rd_q <= rd_d;
    end
  end

  // initiator must not strobe while a data phase is still open
  AST_NO_STROBE_IN_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_DATA && frame) |-> !(bus_start && sel)); // R6

  AST_CAPTURE_OPENS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    capture |=> (beat || !sel)); // R6

endmodule

// File: rtl/mbt_lane_sel.sv
module mbt_lane_sel #(
  parameter int unsigned BYTES = 8,
  localparam int unsigned LGB  = $clog2(BYTES)
) (
  input  logic [2:0]       lg,
  input  logic [LGB-1:0]   off,
  output logic [BYTES-1:0] be
);

  // lane i is enabled when it falls into the same span-sized slot as the offset
  for (genvar i = 0; i < BYTES; i++) begin : g_lane
    assign be[i] = ((LGB'(i) >> lg) == (off >> lg));
  end

endmodule

// File: rtl/mbt_beat_addr.sv
module mbt_beat_addr #(
  parameter int unsigned BYTES = 8,
  parameter int unsigned AW    = 26,
  localparam int unsigned LGB   = $clog2(BYTES),
  localparam int unsigned WAW   = AW - LGB,
  localparam int unsigned MAXLG = mbt_pkg::BURST_LG - LGB
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             capture,
  input  logic             beat,
  input  logic [AW-1:0]    addr_raw,
  input  logic [2:0]       lg_raw,
  output logic [WAW-1:0]   word_q,
  output logic [BYTES-1:0] be_q
);

  logic [MAXLG-1:0] mask_q, mask_d;
  logic [MAXLG-1:0] cnt_q, cnt_d;
  logic [WAW-1:0]   word_d, mask_ext, word_inc;
  logic [BYTES-1:0] be_d, be_raw;
  logic [2:0]       blg;

  mbt_lane_sel #(.BYTES(BYTES)) i_lane (
    .lg (lg_raw),
    .off(addr_raw[LGB-1:0]),
    .be (be_raw)
  );

  assign mask_ext = {{(WAW-MAXLG){1'b0}}, mask_q};
  assign word_inc = word_q + WAW'(1);

  always_comb begin
    blg    = (lg_raw > 3'(LGB)) ? (lg_raw - 3'(LGB)) : 3'd0;
    mask_d = mask_q;
    cnt_d  = cnt_q;
    word_d = word_q;
    be_d   = be_q;
    if (capture) begin
      mask_d = MAXLG'((4'd1 << blg) - 4'd1);
      cnt_d  = '0;
      word_d = addr_raw[AW-1:LGB];
      be_d   = be_raw;
    end else if (beat) begin
      cnt_d  = cnt_q + MAXLG'(1);
      word_d = (word_q & ~mask_ext) | (word_inc & mask_ext);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '0;
      cnt_q  <= '0;
      word_q <= '0;
      be_q   <= '0;
    end else begin
      if (capture || beat) begin
        mask_q <= mask_d;
        cnt_q  <= cnt_d;
        word_q <= word_d;
        be_q   <= be_d;
      end
    end
  end

  AST_BEAT_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    beat |-> (cnt_q <= mask_q)); // R4

  AST_WRAP_IN_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
    beat |=> ((word_q & ~mask_ext) == $past(word_q & ~mask_ext))); // R5

endmodule

// File: rtl/mux_bus_target.sv
module mux_bus_target #(
  parameter int unsigned DW = 64,
  parameter int unsigned AW = 26,
  localparam int unsigned BYTES = DW / 8,
  localparam int unsigned LGB   = $clog2(BYTES),
  localparam int unsigned WAW   = AW - LGB
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_start,
  input  logic             sel,
  input  logic             frame,
  input  logic             rd_nwr,
  input  logic [DW-1:0]    dq_in,
  output logic [DW-1:0]    dq_out,
  output logic             dq_oe,
  output logic [WAW-1:0]   mem_addr,
  output logic             mem_wen,
  output logic [BYTES-1:0] mem_be,
  output logic [DW-1:0]    mem_wdata,
  input  logic [DW-1:0]    mem_rdata
);

  logic             capture, beat, rd_q;
  logic [2:0]       size_code, lg_raw;
  logic [WAW-1:0]   word_q;
  logic [BYTES-1:0] be_q;
  logic             unused_dq;

  assign size_code = dq_in[DW-1 -: 3];
  assign lg_raw    = mbt_pkg::span_lg(size_code);
  assign unused_dq = ^dq_in[DW-4:AW];

  mbt_phase_ctrl i_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_start(bus_start),
    .sel      (sel),
    .frame    (frame),
    .rd_nwr   (rd_nwr),
    .capture  (capture),
    .beat     (beat),
    .rd_q     (rd_q)
  );

  mbt_beat_addr #(.BYTES(BYTES), .AW(AW)) i_addr (
    .clk     (clk),
    .rst_n   (rst_n),
    .capture (capture),
    .beat    (beat),
    .addr_raw(dq_in[AW-1:0]),
    .lg_raw  (lg_raw),
    .word_q  (word_q),
    .be_q    (be_q)
  );

  assign mem_addr  = word_q;
  assign mem_wen   = beat && !rd_q;
  assign mem_be    = be_q;
  assign mem_wdata = dq_in;
  assign dq_oe     = beat && rd_q;
  assign dq_out    = dq_oe ? mem_rdata : '0;

  AST_OE_NOT_IN_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    dq_oe |-> !bus_start); // R8

  AST_RD_WR_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(dq_oe && mem_wen)); // R8

  AST_WRITE_HAS_LANE: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wen |-> (mem_be != '0)); // R9

  AST_UNSELECTED_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_start && !sel) |=> !(dq_oe || mem_wen)); // R10

endmodule

// File: tb/test_mux_bus_target.sv
module test_mux_bus_target;

  localparam int DW = 64;
  localparam int AW = 26;
  localparam int NW = 64;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          bus_start, sel, frame, rd_nwr;
  logic [DW-1:0] dq_in, dq_out, mem_wdata, mem_rdata;
  logic          dq_oe, mem_wen;
  logic [22:0]   mem_addr;
  logic [7:0]    mem_be;

  int checks = 0;
  int fails  = 0;
  int events = 0;

  typedef struct {
    bit          is_rd;
    int unsigned word;
    logic [7:0]  be;
    logic [63:0] data;
  } exp_t;

  exp_t        q[$];
  logic [63:0] bmem    [NW];
  logic [63:0] ref_mem [NW];

  always #2 clk = ~clk;  // 250 MHz

  mux_bus_target #(.DW(DW), .AW(AW)) i_mux_bus_target (
    .clk(clk), .rst_n(rst_n), .bus_start(bus_start), .sel(sel),
    .frame(frame), .rd_nwr(rd_nwr), .dq_in(dq_in), .dq_out(dq_out),
    .dq_oe(dq_oe), .mem_addr(mem_addr), .mem_wen(mem_wen),
    .mem_be(mem_be), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
  );

  assign mem_rdata = bmem[mem_addr[5:0]];

  always @(posedge clk) begin
    if (mem_wen)
      for (int b = 0; b < 8; b++)
        if (mem_be[b]) bmem[mem_addr[5:0]][b*8 +: 8] <= mem_wdata[b*8 +: 8];
  end

  // monitor: pop one expected item per beat
  always @(negedge clk) begin
    if (rst_n && (dq_oe || mem_wen)) begin
      events++;
      checks++;
      if (q.size() == 0) begin
        fails++;
        $display("FAIL R4 R6: unexpected beat oe=%0b wen=%0b addr=%0d, expected none",
                 dq_oe, mem_wen, mem_addr);
      end else begin
        exp_t e;
        e = q.pop_front();
        if (e.is_rd) begin
          if (!dq_oe || mem_wen || mem_addr != 23'(e.word) || dq_out != e.data) begin
            fails++;
            $display("FAIL R5 R8: read addr=%0d data=%h oe=%0b, expected addr=%0d data=%h",
                     mem_addr, dq_out, dq_oe, e.word, e.data);
          end
        end else begin
          if (!mem_wen || dq_oe || mem_addr != 23'(e.word) || mem_be != e.be ||
              mem_wdata != e.data) begin
            fails++;
            $display("FAIL R5 R7 R9: write addr=%0d be=%h data=%h, expected addr=%0d be=%h data=%h",
                     mem_addr, mem_be, mem_wdata, e.word, e.be, e.data);
          end
        end
      end
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    bus_start = 1'b0; sel = 1'b0; frame = 1'b0; dq_in = '0;
    repeat (n) begin @(posedge clk); #1; end
  endtask

  // driver: push expected beats, then run the access on the bus
  task automatic do_cycle(input bit rd, input logic [2:0] code, input int unsigned addr);
    int lg, nb;
    int unsigned w0, m, w;
    logic [7:0]  be;
    logic [63:0] wd [8];
    exp_t e;
    lg = code[2] ? 5 : int'(code[1:0]);
    nb = (lg > 3) ? (1 << (lg - 3)) : 1;
    m  = nb - 1;
    be = (lg >= 3) ? 8'hff
                   : 8'(((1 << (1 << lg)) - 1) << ((addr & 7) & ~((1 << lg) - 1)));
    w0 = (addr >> 3) & (NW - 1);
    for (int k = 0; k < nb; k++) begin
      w = (w0 & ~m) | ((w0 + k) & m);
      e.is_rd = rd; e.word = w; e.be = be;
      if (rd) e.data = ref_mem[w];
      else begin
        e.data = {$urandom, $urandom};
        for (int b = 0; b < 8; b++)
          if (be[b]) ref_mem[w][b*8 +: 8] = e.data[b*8 +: 8];
      end
      wd[k] = e.data;
      q.push_back(e);
    end
    bus_start = 1'b1; sel = 1'b1; frame = 1'b1; rd_nwr = rd;
    dq_in = {code, 35'({$urandom, $urandom}), 26'(addr)};  // R2: junk in unused bits
    @(posedge clk); #1;
    bus_start = 1'b0;
    for (int k = 0; k < nb; k++) begin
      frame = (k != nb - 1);
      dq_in = rd ? {$urandom, $urandom} : wd[k];
      @(posedge clk); #1;
    end
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin : stim
    int ev0;
    for (int i = 0; i < NW; i++) begin
      bmem[i] = {$urandom, $urandom};
      ref_mem[i] = bmem[i];
    end
    rst_n = 1'b0; bus_start = 1'b0; sel = 1'b0; frame = 1'b0; rd_nwr = 1'b0; dq_in = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(!dq_oe && !mem_wen, "R1 reset", int'({dq_oe, mem_wen}), 0);
    @(posedge clk); #1;
    rst_n = 1'b1;
    @(negedge clk);
    check(!dq_oe && !mem_wen, "R1 idle", int'({dq_oe, mem_wen}), 0);
    @(posedge clk); #1;

    // R3 R4 R5 R9: every size code, odd start offsets, write then read back
    for (int c = 0; c < 8; c++) begin
      do_cycle(1'b0, 3'(c), 32'd77 + 32'(c) * 40);
      idle(1);
      do_cycle(1'b1, 3'(c), 32'd77 + 32'(c) * 40);
      idle(2);
    end

    // R6: back-to-back accesses with no idle clock between them
    do_cycle(1'b0, 3'b100, 32'd24);
    do_cycle(1'b1, 3'b111, 32'd8);
    do_cycle(1'b0, 3'b000, 32'd5);
    do_cycle(1'b1, 3'b001, 32'd6);
    idle(2);

    // R10: strobe without select
    ev0 = events;
    bus_start = 1'b1; sel = 1'b0; frame = 1'b0; rd_nwr = 1'b0;
    dq_in = {3'b100, 35'd0, 26'd128};
    @(posedge clk); #1;
    idle(4);
    check(events == ev0, "R10 ignored strobe", events - ev0, 0);
    do_cycle(1'b1, 3'b100, 32'd128);  // memory there must be untouched
    idle(1);

    // random mix
    for (int n = 0; n < 120; n++) begin
      do_cycle(1'($urandom), 3'($urandom), $urandom_range(0, NW * 8 - 1));
      if ($urandom_range(0, 2) != 0) idle($urandom_range(1, 3));
    end
    idle(4);
    check(q.size() == 0, "R4 R6 all beats seen", q.size(), 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule